// File: doc/BRIEF.md
# Two-Step Hashed Field Lookup Lane

This block serves one header field of a multi-field packet classifier. Each field value that arrives with a valid strobe is hashed to 32 bits. The low bits of the hash act as a short search key into a small address table. The remaining upper bits act as a reference tag. The address table returns one slot number, and that slot is read in every candidate memory in the same cycle. Each candidate entry carries a valid bit, a stored tag and a per-rule match vector. A selector forwards the vector of the entry whose tag equals the reference tag. When no valid entry matches, the selector outputs the lane's default vector, which is the set of rules that treat this field as a wildcard.

Hash keys that collide in the short search key are told apart by their stored tags, so the address table can stay small. The lane is fully pipelined. It accepts one field per cycle and makes exactly one access to each internal memory per lookup. Separate write ports load the address table, each candidate memory and the default vector. The contents of these tables are computed elsewhere.

Top module: `hashed_field_lane`

## Requirements
- R1: The hash of a field value F is the 32-bit MurmurHash3 of one 4-byte block holding F. The seed defaults to 0. The block is mixed with constants 0xcc9e2d51 and 0x1b873593 and rotate-left 15. The state is mixed with rotate-left 13, then multiplied by 5 and 0xe6546b64 is added. The length 4 is XORed in, and the standard finalizer is applied (shifts 16/13/16, multipliers 0x85ebca6b and 0xc2b2ae35).
- R2: The search key is hash bits [KEY_W-1:0] and indexes the address table. The reference tag is hash bits [31:KEY_W].
- R3: The slot number read from the address table addresses every candidate memory. An entry in any candidate memory, not only the first, can produce a hit.
- R4: A lookup hits when some candidate entry at that slot has its valid bit set and a stored tag equal to the reference tag. On a hit, out_hit is 1 and out_vec is that entry's vector.
- R5: When no entry at the slot is both valid and tag-equal, out_hit is 0 and out_vec is the default vector. This includes an invalid entry that carries the right tag.
- R6: When several candidate memories match, the one with the lowest index wins.
- R7: A result appears exactly 4 clock cycles after its input is taken. Lookups may be issued back to back on consecutive cycles, and results keep input order.
- R8: After reset, out_valid, out_hit and out_vec are all 0.
- R9: While out_valid is 0, out_hit and out_vec keep their previous values.
- R10: A write on the default-vector port replaces the default vector used by every later miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Field value present this cycle |
| in_field | input | 32 | Header field value |
| out_valid | output | 1 | Result present this cycle |
| out_hit | output | 1 | 1 when a candidate entry matched |
| out_vec | output | RULE_W | Per-rule match vector for this field |
| at_we | input | 1 | Address-table write enable |
| at_waddr | input | KEY_W | Address-table write index (search key) |
| at_wdata | input | CM_AW | Slot number to store |
| cm_we | input | NUM_CM | Per-candidate-memory write enables |
| cm_waddr | input | CM_AW | Candidate slot to write |
| cm_wvld | input | 1 | Valid bit to store |
| cm_wref | input | 32-KEY_W | Tag to store |
| cm_wvec | input | RULE_W | Rule vector to store |
| dflt_we | input | 1 | Default-vector write enable |
| dflt_wdata | input | RULE_W | New default vector |

## Verification
A wrong hash or a wrong key/tag split makes programmed fields miss. They then show the default vector and out_hit low exactly four cycles after issue, where a hit was expected. A wrong slot from the address table, or wrong selector priority, shows on that same result cycle as the vector of the wrong entry. A wrong valid-pipeline register shows as a result on the wrong cycle, a missing result, or an output that drifts while out_valid is low. The bench catches each of these at the first affected lookup.

// File: rtl/lane_pkg.sv
package lane_pkg;
  localparam int HASH_W = 32;

  function automatic logic [31:0] rotl32(input logic [31:0] x, input int n);
    rotl32 = (x << n) | (x >> (32 - n));
  endfunction

  // One 4-byte block MurmurHash3 (32-bit variant)
  function automatic logic [31:0] mix_word(input logic [31:0] key, input logic [31:0] seed);
    logic [31:0] k;
    logic [31:0] h;
    k = key * 32'hcc9e2d51;
    k = rotl32(k, 15);
    k = k * 32'h1b873593;
    h = seed ^ k;
    h = rotl32(h, 13);
    h = h * 32'd5 + 32'he6546b64;
    h = h ^ 32'd4;
    h = h ^ (h >> 16);
    h = h * 32'h85ebca6b;
    h = h ^ (h >> 13);
    h = h * 32'hc2b2ae35;
    h = h ^ (h >> 16);
    mix_word = h;
  endfunction
endpackage

// File: rtl/lane_mix32.sv
module lane_mix32
  import lane_pkg::*;
#(
  parameter logic [31:0] SEED = 32'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vld_i,
  input  logic [HASH_W-1:0] field_i,
  output logic              vld_o,
  output logic [HASH_W-1:0] hash_o
);
  logic              vld_d, vld_q;
  logic [HASH_W-1:0] hash_d, hash_q;

  always_comb begin
    vld_d  = vld_i;
    hash_d = hash_q;
    if (vld_i) hash_d = mix_word(field_i, SEED);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      hash_q <= '0;
    end else begin
      vld_q  <= vld_d;
      hash_q <= hash_d;
    end
  end

  assign vld_o  = vld_q;
  assign hash_o = hash_q;

  AST_HASH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_i |=> $stable(hash_o)); // R9
endmodule

// File: rtl/lane_sram.sv
module lane_sram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata_q <= mem[raddr];
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/lane_pick.sv
module lane_pick #(
  parameter int NCM = 2,
  parameter int RW  = 24,
  parameter int VW  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vld_i,
  input  logic [RW-1:0]     ref_i,
  input  logic [NCM-1:0]    ent_vld_i,
  input  logic [NCM*RW-1:0] ent_ref_i,
  input  logic [NCM*VW-1:0] ent_vec_i,
  input  logic [VW-1:0]     dflt_i,
  output logic              vld_o,
  output logic              hit_o,
  output logic [VW-1:0]     vec_o
);
  logic [NCM-1:0] match;
  logic           vld_d, vld_q;
  logic           hit_d, hit_q;
  logic [VW-1:0]  vec_d, vec_q;

  for (genvar g = 0; g < NCM; g++) begin : g_cmp
    assign match[g] = ent_vld_i[g] && (ent_ref_i[g*RW +: RW] == ref_i);
  end

  always_comb begin
    vld_d = vld_i;
    hit_d = hit_q;
    vec_d = vec_q;
    if (vld_i) begin
      hit_d = 1'b0;
      vec_d = dflt_i;
      for (int i = NCM - 1; i >= 0; i--) begin
        if (match[i]) begin
          hit_d = 1'b1;
          vec_d = ent_vec_i[i*VW +: VW];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      hit_q <= 1'b0;
      vec_q <= '0;
    end else begin
      vld_q <= vld_d;
      hit_q <= hit_d;
      vec_q <= vec_d;
    end
  end

  assign vld_o = vld_q;
  assign hit_o = hit_q;
  assign vec_o = vec_q;

  AST_MISS_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && match == '0) |=> (!hit_o && vec_o == $past(dflt_i))); // R5
  AST_FIRST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && match[0]) |=> (hit_o && vec_o == $past(ent_vec_i[VW-1:0]))); // R6
endmodule

// File: rtl/hashed_field_lane.sv
module hashed_field_lane
  import lane_pkg::*;
#(
  parameter int          KEY_W  = 8,
  parameter int          CM_AW  = 6,
  parameter int          NUM_CM = 2,
  parameter int          RULE_W = 16,
  parameter logic [31:0] SEED   = 32'h0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [31:0]             in_field,
  output logic                    out_valid,
  output logic                    out_hit,
  output logic [RULE_W-1:0]       out_vec,
  input  logic                    at_we,
  input  logic [KEY_W-1:0]        at_waddr,
  input  logic [CM_AW-1:0]        at_wdata,
  input  logic [NUM_CM-1:0]       cm_we,
  input  logic [CM_AW-1:0]        cm_waddr,
  input  logic                    cm_wvld,
  input  logic [31-KEY_W:0]       cm_wref,
  input  logic [RULE_W-1:0]       cm_wvec,
  input  logic                    dflt_we,
  input  logic [RULE_W-1:0]       dflt_wdata
);
  localparam int REF_W = HASH_W - KEY_W;
  localparam int CM_DW = 1 + REF_W + RULE_W;
  localparam int LAT   = 4;

  // stage 1: hash
  logic              s1_vld;
  logic [HASH_W-1:0] s1_hash;

  lane_mix32 #(.SEED(SEED)) u_mix (
    .clk(clk), .rst_n(rst_n), .vld_i(in_valid), .field_i(in_field),
    .vld_o(s1_vld), .hash_o(s1_hash)
  );

  // stage 2: address table read
  logic [CM_AW-1:0] slot;

  lane_sram #(.AW(KEY_W), .DW(CM_AW)) u_atab (
    .clk(clk), .we(at_we), .waddr(at_waddr), .wdata(at_wdata),
    .re(s1_vld), .raddr(s1_hash[KEY_W-1:0]), .rdata(slot)
  );

  logic             s2_vld_d, s2_vld_q, s3_vld_d, s3_vld_q;
  logic [REF_W-1:0] s2_ref_d, s2_ref_q, s3_ref_d, s3_ref_q;
  logic [RULE_W-1:0] dflt_d, dflt_q;

  always_comb begin
    s2_vld_d = s1_vld;
    s2_ref_d = s2_ref_q;
    if (s1_vld) s2_ref_d = s1_hash[HASH_W-1:KEY_W];
    s3_vld_d = s2_vld_q;
    s3_ref_d = s3_ref_q;
    if (s2_vld_q) s3_ref_d = s2_ref_q;
    dflt_d = dflt_q;
    if (dflt_we) dflt_d = dflt_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_vld_q <= 1'b0;
      s2_ref_q <= '0;
      s3_vld_q <= 1'b0;
      s3_ref_q <= '0;
      dflt_q   <= '0;
    end else begin
      s2_vld_q <= s2_vld_d;
      s2_ref_q <= s2_ref_d;
      s3_vld_q <= s3_vld_d;
      s3_ref_q <= s3_ref_d;
      dflt_q   <= dflt_d;
    end
  end

  // stage 3: candidate memories, all read at the same slot
  logic [NUM_CM-1:0]        ent_vld;
  logic [NUM_CM*REF_W-1:0]  ent_ref;
  logic [NUM_CM*RULE_W-1:0] ent_vec;

  for (genvar g = 0; g < NUM_CM; g++) begin : g_cm
    logic [CM_DW-1:0] rd;
    lane_sram #(.AW(CM_AW), .DW(CM_DW)) u_cm (
      .clk(clk), .we(cm_we[g]), .waddr(cm_waddr),
      .wdata({cm_wvld, cm_wref, cm_wvec}),
      .re(s2_vld_q), .raddr(slot), .rdata(rd)
    );
    assign ent_vld[g]                   = rd[CM_DW-1];
    assign ent_ref[g*REF_W +: REF_W]    = rd[RULE_W +: REF_W];
    assign ent_vec[g*RULE_W +: RULE_W]  = rd[RULE_W-1:0];
  end

  // stage 4: select
  lane_pick #(.NCM(NUM_CM), .RW(REF_W), .VW(RULE_W)) u_pick (
    .clk(clk), .rst_n(rst_n), .vld_i(s3_vld_q), .ref_i(s3_ref_q),
    .ent_vld_i(ent_vld), .ent_ref_i(ent_ref), .ent_vec_i(ent_vec),
    .dflt_i(dflt_q), .vld_o(out_valid), .hit_o(out_hit), .vec_o(out_vec)
  );

  // in-flight counter for latency checks
  logic [3:0] chk_pend;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chk_pend <= '0;
    else        chk_pend <= chk_pend + {3'b0, in_valid} - {3'b0, out_valid};
  end

  AST_PEND_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    chk_pend <= 4'(LAT)); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_pend == 4'd0 && !in_valid) |=> !out_valid); // R7
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_vec) && $stable(out_hit))); // R9
endmodule

// File: tb/test_hashed_field_lane.sv
module test_hashed_field_lane;
  localparam int CLK_PERIOD = 10;
  localparam int KW = 8;
  localparam int AW = 6;
  localparam int NC = 2;
  localparam int VW = 16;
  localparam int RW = 32 - KW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [31:0] in_field = '0;
  logic out_valid, out_hit;
  logic [VW-1:0] out_vec;
  logic at_we = 1'b0;
  logic [KW-1:0] at_waddr = '0;
  logic [AW-1:0] at_wdata = '0;
  logic [NC-1:0] cm_we = '0;
  logic [AW-1:0] cm_waddr = '0;
  logic cm_wvld = 1'b0;
  logic [RW-1:0] cm_wref = '0;
  logic [VW-1:0] cm_wvec = '0;
  logic dflt_we = 1'b0;
  logic [VW-1:0] dflt_wdata = '0;

  hashed_field_lane i_hashed_field_lane (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_field(in_field),
    .out_valid(out_valid), .out_hit(out_hit), .out_vec(out_vec),
    .at_we(at_we), .at_waddr(at_waddr), .at_wdata(at_wdata),
    .cm_we(cm_we), .cm_waddr(cm_waddr), .cm_wvld(cm_wvld),
    .cm_wref(cm_wref), .cm_wvec(cm_wvec),
    .dflt_we(dflt_we), .dflt_wdata(dflt_wdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;

  // table models
  logic [AW-1:0] at_m [1<<KW];
  logic          cm_v [NC][1<<AW];
  logic [RW-1:0] cm_r [NC][1<<AW];
  logic [VW-1:0] cm_d [NC][1<<AW];
  logic [VW-1:0] dflt_m = '0;

  // expected-result queue
  logic [VW-1:0] q_vec [1024];
  logic          q_hit [1024];
  int            q_cyc [1024];
  string         q_req [1024];
  int wr_p = 0;
  int rd_p = 0;
  bit mon_en = 1'b0;
  logic [VW-1:0] last_vec = '0;
  logic          last_hit = 1'b0;
  logic [31:0] prog [64];
  int nprog = 0;

  function automatic logic [31:0] rl(input logic [31:0] x, input int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  function automatic logic [31:0] ref_hash(input logic [31:0] f);
    logic [31:0] k, h;
    k = rl(f * 32'hcc9e2d51, 15) * 32'h1b873593;
    h = rl(32'h0 ^ k, 13) * 32'd5 + 32'he6546b64;
    h = h ^ 32'd4;
    h = (h ^ (h >> 16)) * 32'h85ebca6b;
    h = (h ^ (h >> 13)) * 32'hc2b2ae35;
    return h ^ (h >> 16);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic wr_at(input logic [KW-1:0] k, input logic [AW-1:0] a);
    @(negedge clk);
    in_valid = 1'b0; at_we = 1'b1; at_waddr = k; at_wdata = a; at_m[k] = a;
    @(negedge clk);
    at_we = 1'b0;
  endtask

  task automatic wr_cm(input int j, input logic [AW-1:0] a, input logic v,
                       input logic [RW-1:0] r, input logic [VW-1:0] d);
    @(negedge clk);
    in_valid = 1'b0; cm_we = '0; cm_we[j] = 1'b1;
    cm_waddr = a; cm_wvld = v; cm_wref = r; cm_wvec = d;
    cm_v[j][a] = v; cm_r[j][a] = r; cm_d[j][a] = d;
    @(negedge clk);
    cm_we = '0;
  endtask

  task automatic wr_dflt(input logic [VW-1:0] d);
    @(negedge clk);
    in_valid = 1'b0; dflt_we = 1'b1; dflt_wdata = d; dflt_m = d;
    @(negedge clk);
    dflt_we = 1'b0;
  endtask

  // issue one lookup at this negedge; expected value from the model
  task automatic look(input logic [31:0] f, input string req);
    logic [31:0] h;
    logic [AW-1:0] a;
    @(negedge clk);
    in_valid = 1'b1; in_field = f;
    h = ref_hash(f);
    a = at_m[h[KW-1:0]];
    q_hit[wr_p % 1024] = 1'b0;
    q_vec[wr_p % 1024] = dflt_m;
    for (int j = NC - 1; j >= 0; j--) begin
      if (cm_v[j][a] && cm_r[j][a] == h[31:KW]) begin
        q_hit[wr_p % 1024] = 1'b1;
        q_vec[wr_p % 1024] = cm_d[j][a];
      end
    end
    q_cyc[wr_p % 1024] = cyc;
    q_req[wr_p % 1024] = req;
    wr_p++;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // output monitor
  always @(negedge clk) begin
    if (mon_en) begin
      if (out_valid) begin
        if (rd_p == wr_p) begin
          check(1'b0, "R7 spurious result", {31'b0, out_valid}, 32'h0);
        end else begin
          check(cyc - q_cyc[rd_p % 1024] == 4, "R7 latency",
                32'(cyc - q_cyc[rd_p % 1024]), 32'd4);
          check(out_hit == q_hit[rd_p % 1024], {q_req[rd_p % 1024], " hit flag"},
                {31'b0, out_hit}, {31'b0, q_hit[rd_p % 1024]});
          check(out_vec == q_vec[rd_p % 1024], {q_req[rd_p % 1024], " vector"},
                {16'b0, out_vec}, {16'b0, q_vec[rd_p % 1024]});
          rd_p++;
        end
        last_vec = out_vec;
        last_hit = out_hit;
      end else begin
        check(out_vec == last_vec && out_hit == last_hit, "R9 hold while idle",
              {15'b0, out_hit, out_vec}, {15'b0, last_hit, last_vec});
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] f, h, s;
    logic [AW-1:0] a;
    s = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    // R8: reset values
    check(out_valid == 1'b0, "R8 out_valid", {31'b0, out_valid}, 32'h0);
    check(out_hit == 1'b0, "R8 out_hit", {31'b0, out_hit}, 32'h0);
    check(out_vec == '0, "R8 out_vec", {16'b0, out_vec}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    mon_en = 1'b1;

    // initialise all tables
    for (int k = 0; k < (1 << KW); k++) wr_at(KW'(k), AW'($urandom));
    for (int j = 0; j < NC; j++)
      for (int a2 = 0; a2 < (1 << AW); a2++) wr_cm(j, AW'(a2), 1'b0, RW'($urandom), VW'($urandom));
    wr_dflt(16'hA5A5);

    // program entries for random fields (R1, R2, R4)
    for (int i = 0; i < 40; i++) begin
      f = $urandom;
      h = ref_hash(f);
      prog[i] = f;
      wr_cm(int'($urandom % NC), at_m[h[KW-1:0]], 1'b1, h[31:KW], VW'($urandom));
    end
    nprog = 40;
    idle(2);
    for (int i = 0; i < nprog; i++) look(prog[i], "R4 R1 programmed");
    idle(6);

    // R6: both memories match, lowest index wins
    f = 32'h0000_0000; h = ref_hash(f); a = at_m[h[KW-1:0]];
    wr_cm(0, a, 1'b1, h[31:KW], 16'h1111);
    wr_cm(1, a, 1'b1, h[31:KW], 16'h2222);
    look(f, "R6 priority"); idle(6);
    // R3: only the second memory matches
    wr_cm(0, a, 1'b1, ~h[31:KW], 16'h3333);
    look(f, "R3 second memory"); idle(6);
    // R5: invalid entries carrying the right tag
    wr_cm(0, a, 1'b0, h[31:KW], 16'h4444);
    wr_cm(1, a, 1'b0, h[31:KW], 16'h5555);
    look(f, "R5 invalid tag match"); idle(6);
    // R5: valid entries with wrong tag
    wr_cm(0, a, 1'b1, h[31:KW] ^ 24'h1, 16'h6666);
    look(f, "R5 tag mismatch"); idle(6);
    // R10: new default vector used by later misses
    wr_dflt(16'h0F0F);
    look(f, "R10 new default"); idle(6);
    // R2: retarget the address-table entry to a slot holding a match
    wr_cm(1, AW'(a + 1), 1'b1, h[31:KW], 16'h7777);
    wr_at(h[KW-1:0], AW'(a + 1));
    look(f, "R2 address table slot"); idle(6);

    // R7: back-to-back random stream with occasional gaps
    for (int i = 0; i < 300; i++) begin
      if ($urandom % 4 == 0) idle(1 + int'($urandom % 3));
      if ($urandom % 10 < 7) look(prog[$urandom % nprog], "R4 stream");
      else                   look($urandom, "R5 stream");
    end
    idle(10);
    check(rd_p == wr_p, "R7 all results returned", 32'(rd_p), 32'(wr_p));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule